// File: doc/BRIEF.md
# SMBus host transaction controller

This block is a register-driven SMBus host. Software loads a target address with its direction bit, a command byte, a byte count and up to eight data bytes. It then writes a start command that carries a protocol code. The controller runs the full SMBus transaction for that code: quick, send/receive byte, byte-data, word-data, process call or block transfer. It works through a byte-level engine that performs the start, stop, write-byte and read-byte steps on the wire. Results, errors and chunk handshakes appear as sticky status bits that software clears by writing ones.

Block transfers carry up to 32 bytes through a window of only eight data registers. The controller stops after each 8-byte chunk, raises a byte-done flag and keeps the bus until software refills the window (write) or empties it (read) and clears the flag. A kill command drops any transaction at once. An optional timeout abandons a transaction whose engine handshake never completes.

Top module: `smbus_host_ctrl`

## Requirements
- R1: After reset, every register reads as zero, both busy bits are low and no engine request is raised.
- R2: Offset 0x04 holds the address byte (7-bit target in bits 7:1, bit 0 = 1 for read), 0x05 the command, 0x07 a 6-bit count, 0x08..0x0F the data window; control offset 0x02 bit 6 enables the timeout and bit 5 selects the fast bus clock, which also drives `fast_clk`; all of them read back.
- R3: Status offset 0x00 has bit 4 byte-done, bit 3 complete, bit 2 collision, bit 1 device error. Each bit is sticky and is cleared by writing 1 to it. Complete sets when the stop handshake finishes, and host-busy (control bit 0) clears at that moment.
- R4: Writing offset 0x03 with bit 4 set and bits 2:0 = protocol code (0 quick, 1 byte, 2 byte-data, 3 word-data, 4 process call, 5 block) starts a transaction. The start is ignored while host-busy is set and ignored for codes 6 and 7.
- R5: The engine request encodes `eng_op` as 0 start, 1 stop, 2 write byte, 3 read byte. A request stays raised with a stable op until `eng_done` arrives.
- R6: Quick sends only the address byte. Byte write sends the command; byte read sends the read address alone and reads one byte without acknowledging it. Byte-data and word-data writes send the command and then one or two bytes (low byte from window 0). Their reads send the command, a repeated start and the read address, then read one or two bytes, acknowledging all but the last.
- R7: A process call writes the command and the two window bytes, issues a repeated start with the read address, and returns two bytes into window 0 (low) and 1 (high), regardless of the direction bit.
- R8: A block write sends the command, then min(count, 32) as the count byte, then that many data bytes. After each 8 bytes with more left, it sets byte-done, raises no request, and resumes only once byte-done is cleared.
- R9: A block read sends the command, a repeated start and the read address, then reads a count byte, clamps it to 32 and stores it in the count register. It reads that many bytes, acknowledging all but the last, and pauses with byte-done after every chunk of 8 and after the final chunk, before the stop.
- R10: A write byte that the target does not acknowledge sets device error, is followed by a stop, and the transaction ends with complete set.
- R11: An engine completion flagged as arbitration lost sets collision and drops both busy bits without issuing a stop.
- R12: Writing bit 5 of offset 0x03 aborts any transaction. The cycle after, both busy bits are low and `eng_abort` is high, and a later start is accepted.
- R13: With the timeout enabled, a request left incomplete for TMO_CYCLES cycles sets device error and aborts the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| fast_clk | output | 1 | Fast bus clock select to the bit timer |
| eng_req | output | 1 | Byte engine request |
| eng_op | output | 2 | Engine operation (0 start, 1 stop, 2 write, 3 read) |
| eng_txd | output | 8 | Byte to transmit |
| eng_ack_out | output | 1 | Acknowledge to send after a read byte |
| eng_abort | output | 1 | One-cycle pulse telling the engine to release the bus |
| eng_done | input | 1 | Engine completed the requested operation |
| eng_rxd | input | 8 | Byte received by a read |
| eng_ack_in | input | 1 | Target acknowledged the written byte |
| eng_lost | input | 1 | Arbitration lost during the operation |

## Verification
The bench builds the controller with TMO_CYCLES set to 40 instead of 1000. This lets the timeout abort fire within a few dozen stalled cycles and leaves room for the many random transactions. Block lengths 0, 8, 9, 32 and counts above 32 bring every chunk boundary and both clamps within reach. A stalling byte-engine model exercises kill, a start ignored while busy, and the timeout while a request is held.

// File: rtl/smbus_host_ctrl.sv
`timescale 1ns/1ps
module smbus_host_ctrl #(
  parameter int TMO_CYCLES = 1000,
  parameter int WIN_BYTES  = 8,
  parameter int MAX_BLOCK  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       fast_clk,
  output logic       eng_req,
  output logic [1:0] eng_op,
  output logic [7:0] eng_txd,
  output logic       eng_ack_out,
  output logic       eng_abort,
  input  logic       eng_done,
  input  logic [7:0] eng_rxd,
  input  logic       eng_ack_in,
  input  logic       eng_lost
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam int WI = $clog2(WIN_BYTES);
  localparam int CW = $clog2(MAX_BLOCK + 1);

  typedef enum logic [3:0] {IDLE, START, ADDR, CMD, CNT_W, WR, RSTART, ADDR_R, CNT_R, RD, HOLD, STOP} st_t;

  st_t st;
  logic [2:0] proto;
  logic [7:0] a_reg, c_reg;
  logic [CW-1:0] cnt_reg, bcnt, len;
  logic [7:0] win [WIN_BYTES];
  logic to_en, clk_sel, bus_busy, host_busy;
  logic s_bd, s_done, s_col, s_err;
  logic [TW-1:0] tmo;

  wire hc_we = reg_we && reg_addr == 4'h3;
  wire kill = hc_we && reg_wdata[5];
  wire go = hc_we && reg_wdata[4] && !reg_wdata[5] && reg_wdata[2:0] <= 3'd5 && st == IDLE;
  wire rd_dir = a_reg[0];
  wire [CW-1:0] blen = (cnt_reg > CW'(MAX_BLOCK)) ? CW'(MAX_BLOCK) : cnt_reg;
  wire [CW-1:0] rx_len = (eng_rxd > 8'(MAX_BLOCK)) ? CW'(MAX_BLOCK) : CW'(eng_rxd);
  wire last = (bcnt + 1'b1) == len;
  wire chunk_end = &bcnt[WI-1:0];
  wire fin = eng_req && eng_done;
  wire nack = fin && eng_op == 2'd2 && !eng_ack_in;
  wire tmo_hit = to_en && eng_req && !eng_done && tmo == TW'(TMO_CYCLES - 1);

  assign host_busy = st != IDLE;
  assign fast_clk = clk_sel;
  assign eng_req = !(st inside {IDLE, HOLD});
  assign eng_ack_out = (st == CNT_R) || !last;

  always_comb
    case (proto)
      3'd1, 3'd2: len = CW'(1);
      3'd3, 3'd4: len = CW'(2);
      default:    len = blen;
    endcase

  always_comb
    case (st)
      START, RSTART: eng_op = 2'd0;
      STOP:          eng_op = 2'd1;
      CNT_R, RD:     eng_op = 2'd3;
      default:       eng_op = 2'd2;
    endcase

  always_comb
    case (st)
      ADDR:    eng_txd = (proto <= 3'd1) ? a_reg : {a_reg[7:1], 1'b0};
      ADDR_R:  eng_txd = {a_reg[7:1], 1'b1};
      CMD:     eng_txd = c_reg;
      CNT_W:   eng_txd = 8'(blen);
      WR:      eng_txd = win[bcnt[WI-1:0]];
      default: eng_txd = 8'h00;
    endcase

  always_comb
    if (reg_addr[3]) reg_rdata = win[reg_addr[WI-1:0]];
    else
      case (reg_addr[2:0])
        3'd0:    reg_rdata = {3'b0, s_bd, s_done, s_col, s_err, 1'b0};
        3'd2:    reg_rdata = {1'b0, to_en, clk_sel, 3'b0, bus_busy, host_busy};
        3'd3:    reg_rdata = {5'b0, proto};
        3'd4:    reg_rdata = a_reg;
        3'd5:    reg_rdata = c_reg;
        3'd7:    reg_rdata = 8'(cnt_reg);
        default: reg_rdata = 8'h00;
      endcase

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; proto <= '0; a_reg <= '0; c_reg <= '0; cnt_reg <= '0; bcnt <= '0;
      to_en <= 1'b0; clk_sel <= 1'b0; bus_busy <= 1'b0; eng_abort <= 1'b0;
      s_bd <= 1'b0; s_done <= 1'b0; s_col <= 1'b0; s_err <= 1'b0; tmo <= '0;
      for (int i = 0; i < WIN_BYTES; i++) win[i] <= '0;
    end else begin
      eng_abort <= 1'b0;
      tmo <= (to_en && eng_req && !eng_done) ? tmo + 1'b1 : '0;
      if (reg_we) begin
        if (reg_addr[3]) win[reg_addr[WI-1:0]] <= reg_wdata;
        else
          case (reg_addr[2:0])
            3'd0: begin
              if (reg_wdata[4]) s_bd <= 1'b0;
              if (reg_wdata[3]) s_done <= 1'b0;
              if (reg_wdata[2]) s_col <= 1'b0;
              if (reg_wdata[1]) s_err <= 1'b0;
            end
            3'd2: begin to_en <= reg_wdata[6]; clk_sel <= reg_wdata[5]; end
            3'd4: a_reg <= reg_wdata;
            3'd5: c_reg <= reg_wdata;
            3'd7: cnt_reg <= CW'(reg_wdata);
            default: ;
          endcase
      end

      if (go) begin
        st <= START; proto <= reg_wdata[2:0]; bcnt <= '0;
      end else if (kill || tmo_hit) begin
        st <= IDLE; bus_busy <= 1'b0; eng_abort <= 1'b1; tmo <= '0;
        if (tmo_hit) s_err <= 1'b1;
      end else if (fin && eng_lost) begin
        st <= IDLE; bus_busy <= 1'b0; s_col <= 1'b1;
      end else if (nack) begin
        st <= STOP; s_err <= 1'b1;
      end else if (fin) begin
        case (st)
          START:  begin st <= ADDR; bus_busy <= 1'b1; end
          ADDR:   st <= (proto == 3'd0) ? STOP : (proto == 3'd1 && rd_dir) ? RD : CMD;
          CMD:
            case (proto)
              3'd1:       st <= STOP;
              3'd2, 3'd3: st <= rd_dir ? RSTART : WR;
              3'd4:       st <= WR;
              default:    st <= rd_dir ? RSTART : CNT_W;
            endcase
          CNT_W:  st <= (blen == '0) ? STOP : WR;
          WR: begin
            bcnt <= bcnt + 1'b1;
            if (last) begin
              if (proto == 3'd4) begin st <= RSTART; bcnt <= '0; end
              else st <= STOP;
            end else if (proto == 3'd5 && chunk_end) begin
              st <= HOLD; s_bd <= 1'b1;
            end
          end
          RSTART: st <= ADDR_R;
          ADDR_R: st <= (proto == 3'd5) ? CNT_R : RD;
          CNT_R: begin
            cnt_reg <= rx_len;
            st <= (rx_len == '0) ? STOP : RD;
          end
          RD: begin
            win[bcnt[WI-1:0]] <= eng_rxd;
            bcnt <= bcnt + 1'b1;
            if (proto == 3'd5 && (last || chunk_end)) begin
              st <= HOLD; s_bd <= 1'b1;
            end else if (last) st <= STOP;
          end
          STOP: begin st <= IDLE; bus_busy <= 1'b0; s_done <= 1'b1; end
          default: ;
        endcase
      end else if (st == HOLD && !s_bd) begin
        st <= (bcnt == len) ? STOP : (rd_dir ? RD : WR);
      end
    end
  end
endmodule

// File: rtl/smbus_host_chk.sv
`timescale 1ns/1ps
module smbus_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kill,
  input logic       tmo_hit,
  input logic       eng_req,
  input logic [1:0] eng_op,
  input logic       eng_done,
  input logic       eng_lost,
  input logic       host_busy,
  input logic       bus_busy,
  input logic       s_bd,
  input logic       s_done,
  input logic       s_err
);
  // R12
  kill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!host_busy && !bus_busy));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done && !kill && !tmo_hit) |=> (eng_req && $stable(eng_op)));

  // R3
  stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_op == 2'd1 && !eng_lost && !kill) |=> (!host_busy && !bus_busy && s_done));

  // R8
  chunk_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bd) |-> !eng_req);

  // R13
  tmo_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (!host_busy && s_err));
endmodule

bind smbus_host_ctrl smbus_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .kill(kill), .tmo_hit(tmo_hit),
  .eng_req(eng_req), .eng_op(eng_op), .eng_done(eng_done), .eng_lost(eng_lost),
  .host_busy(host_busy), .bus_busy(bus_busy), .s_bd(s_bd), .s_done(s_done), .s_err(s_err)
);

// File: tb/tb_smbus_host_ctrl.sv
`timescale 1ns/1ps
module tb_smbus_host_ctrl;
  localparam int TMO = 40;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, eng_txd;
  logic fast_clk, eng_req, eng_ack_out, eng_abort;
  logic [1:0] eng_op;
  logic eng_done = 0, eng_ack_in = 1, eng_lost = 0;
  logic [7:0] eng_rxd = 0;

  smbus_host_ctrl #(.TMO_CYCLES(TMO)) dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic stall = 0, lost_next = 0;
  int nack_at = -1, wr_n = 0, ridx = 0, dly = 0, nlog = 0, ne = 0;
  logic [7:0] resp [0:40];
  logic [7:0] wdat [0:31];
  logic [10:0] lg [0:127];
  logic [10:0] ex [0:127];

  // byte engine model: logs {op, byte, ack}
  always @(negedge clk) begin
    if (eng_done) begin eng_done = 0; eng_lost = 0; end
    else if (eng_req && !stall) begin
      if (dly > 0) dly--;
      else begin
        dly = $urandom_range(2, 0);
        eng_done = 1; eng_ack_in = 1; eng_lost = lost_next; lost_next = 0;
        if (nlog < 128) lg[nlog] = {eng_op, (eng_op == 2'd2) ? eng_txd : 8'h00, (eng_op == 2'd3) ? eng_ack_out : 1'b0};
        nlog++;
        if (eng_op == 2'd2) begin if (wr_n == nack_at) eng_ack_in = 0; wr_n++; end
        if (eng_op == 2'd3) begin eng_rxd = resp[ridx]; if (ridx < 40) ridx++; end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input logic ack);
    ex[ne] = {op, (op == 2'd2) ? b : 8'h00, (op == 2'd3) ? ack : 1'b0};
    ne++;
  endtask

  task automatic build(input logic [2:0] p, input logic [6:0] a, input logic rdir, input logic [7:0] cmd, input int n);
    ne = 0;
    push(0, 0, 0);
    case (p)
      3'd0: push(2, {a, rdir}, 0);
      3'd1: begin push(2, {a, rdir}, 0); if (rdir) push(3, 0, 0); else push(2, cmd, 0); end
      3'd4: begin
        push(2, {a, 1'b0}, 0); push(2, cmd, 0); push(2, wdat[0], 0); push(2, wdat[1], 0);
        push(0, 0, 0); push(2, {a, 1'b1}, 0); push(3, 0, 1); push(3, 0, 0);
      end
      default: begin
        push(2, {a, 1'b0}, 0); push(2, cmd, 0);
        if (p == 3'd5 && !rdir) push(2, 8'(n), 0);
        if (rdir) begin
          push(0, 0, 0); push(2, {a, 1'b1}, 0);
          if (p == 3'd5) push(3, 0, 1);
          for (int i = 0; i < n; i++) push(3, 0, i != n - 1);
        end else
          for (int i = 0; i < n; i++) push(2, wdat[i], 0);
      end
    endcase
    push(1, 0, 0);
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    chk(req, "transfer count", nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++) if (bad < 0 && lg[i] !== ex[i]) bad = i;
    if (bad < 0) chk(req, "transfer sequence", 0, 0);
    else chk(req, "transfer step", int'(lg[bad]), int'(ex[bad]));
  endtask

  task automatic clear_log();
    nlog = 0; ridx = 0; wr_n = 0;
  endtask

  task automatic wait_end(input string req, output logic [7:0] s);
    int k = 0;
    do begin rd(0, s); k++; end while ((s & 8'h0c) == 0 && k < 3000);
    if (k >= 3000) chk(req, "completion wait", 0, 1);
  endtask

  task automatic run_simple(input logic [2:0] p, input logic [6:0] a, input logic rdir, input logic [7:0] cmd);
    logic [7:0] s, v;
    for (int i = 0; i < 2; i++) resp[i] = 8'($urandom);
    clear_log();
    wr(4, {a, rdir}); wr(5, cmd); wr(8, wdat[0]); wr(9, wdat[1]); wr(0, 8'h1e);
    wr(3, 8'h10 | 8'(p));
    wait_end("R6", s);
    chk("R3", "status after transaction", s, 8'h08);
    rd(2, v); chk("R3", "busy bits after stop", v & 8'h03, 0);
    build(p, a, rdir, cmd, (p == 3'd3) ? 2 : 1);
    cmp_log(p == 3'd4 ? "R7" : "R6");
    if (p == 3'd4 || (rdir && p != 3'd0)) begin
      rd(8, v); chk(p == 3'd4 ? "R7" : "R6", "read data low", v, resp[0]);
      if (p >= 3'd3) begin rd(9, v); chk(p == 3'd4 ? "R7" : "R6", "read data high", v, resp[1]); end
    end
  endtask

  task automatic run_bwrite(input logic [6:0] a, input logic [7:0] cmd, input int cnt);
    int len = (cnt > 32) ? 32 : cnt;
    int sent, pauses = 0, k = 0;
    logic [7:0] s;
    for (int i = 0; i < 32; i++) wdat[i] = 8'($urandom);
    clear_log();
    sent = (len < 8) ? len : 8;
    for (int i = 0; i < sent; i++) wr(4'(8 + i), wdat[i]);
    wr(7, 8'(cnt)); wr(4, {a, 1'b0}); wr(5, cmd); wr(0, 8'h1e); wr(3, 8'h15);
    do begin
      rd(0, s); k++;
      if (s[4]) begin
        pauses++;
        for (int i = 0; i < 8 && sent < len; i++) begin wr(4'(8 + i), wdat[sent]); sent++; end
        wr(0, 8'h10);
      end
    end while (!s[3] && k < 3000);
    chk("R8", "block write status", s, 8'h08);
    chk("R8", "block write pauses", pauses, (len > 0) ? (len - 1) / 8 : 0);
    build(5, a, 0, cmd, len);
    cmp_log("R8");
  endtask

  task automatic run_bread(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] cb);
    int len = (cb > 32) ? 32 : int'(cb);
    int got = 0, pauses = 0, k = 0, bad = 0;
    logic [7:0] s, v;
    resp[0] = cb;
    for (int i = 1; i <= 33; i++) resp[i] = 8'($urandom);
    clear_log();
    wr(4, {a, 1'b1}); wr(5, cmd); wr(0, 8'h1e); wr(3, 8'h15);
    do begin
      rd(0, s); k++;
      if (s[4]) begin
        if (pauses == 0) begin rd(7, v); chk("R9", "clamped count", v, len); end
        pauses++;
        for (int i = 0; i < 8 && got < len; i++) begin
          rd(4'(8 + i), v);
          if (v !== resp[1 + got]) bad++;
          got++;
        end
        wr(0, 8'h10);
      end
    end while (!s[3] && k < 3000);
    chk("R9", "block read status", s, 8'h08);
    chk("R9", "block read bytes", got, len);
    chk("R9", "block read data mismatches", bad, 0);
    chk("R9", "block read pauses", pauses, (len + 7) / 8);
    build(5, a, 1, cmd, len);
    cmp_log("R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd(0, v); chk("R1", "status at reset", v, 0);
    rd(2, v); chk("R1", "control at reset", v, 0);
    rd(7, v); chk("R1", "count at reset", v, 0);
    chk("R1", "request at reset", eng_req, 0);

    // R2 register map
    wr(2, 8'h60); rd(2, v); chk("R2", "control readback", v, 8'h60);
    chk("R2", "fast clock pin", fast_clk, 1);
    wr(2, 8'h00); chk("R2", "fast clock pin off", fast_clk, 0);
    wr(4, 8'ha5); rd(4, v); chk("R2", "address readback", v, 8'ha5);
    wr(7, 8'hff); rd(7, v); chk("R2", "count is 6 bits", v, 8'h3f);
    wr(4'hb, 8'h3c); rd(4'hb, v); chk("R2", "window readback", v, 8'h3c);

    // R4 invalid code ignored
    clear_log();
    wr(3, 8'h17); repeat (4) @(negedge clk);
    rd(2, v); chk("R4", "code 7 not started", v & 8'h01, 0);
    chk("R4", "code 7 no transfer", nlog, 0);

    // directed simple protocols
    wdat[0] = 8'h12; wdat[1] = 8'h34;
    for (int p = 0; p < 5; p++) begin
      run_simple(3'(p), 7'h50, 1'b0, 8'h9a);
      run_simple(3'(p), 7'h2b, 1'b1, 8'h07);
    end

    // random simple protocols
    for (int it = 0; it < 40; it++) begin
      wdat[0] = 8'($urandom); wdat[1] = 8'($urandom);
      run_simple(3'($urandom_range(4, 0)), 7'($urandom), 1'($urandom), 8'($urandom));
    end

    // R4 start while busy ignored
    stall = 1; clear_log();
    wr(4, 8'h44); wr(0, 8'h1e); wr(3, 8'h10);
    repeat (5) @(negedge clk);
    rd(2, v); chk("R4", "host busy during stall", v & 8'h01, 1);
    wr(3, 8'h12);
    stall = 0;
    wait_end("R4", v);
    build(0, 7'h22, 0, 0, 0); cmp_log("R4");

    // R10 nack on command byte
    clear_log(); nack_at = 1;
    wr(4, 8'h60); wr(5, 8'h11); wr(0, 8'h1e); wr(3, 8'h12);
    wait_end("R10", v); nack_at = -1;
    chk("R10", "status after nack", v, 8'h0a);
    ne = 0; push(0, 0, 0); push(2, 8'h60, 0); push(2, 8'h11, 0); push(1, 0, 0);
    cmp_log("R10");

    // R11 collision
    clear_log(); lost_next = 1;
    wr(4, 8'h60); wr(0, 8'h1e); wr(3, 8'h11);
    wait_end("R11", v);
    chk("R11", "status after collision", v, 8'h04);
    rd(2, v); chk("R11", "busy after collision", v & 8'h03, 0);
    chk("R11", "no stop after loss", nlog, 1);

    // R12 kill
    stall = 1; clear_log();
    wr(4, 8'h60); wr(0, 8'h1e); wr(3, 8'h13);
    repeat (6) @(negedge clk);
    rd(2, v); chk("R12", "busy before kill", v & 8'h01, 1);
    wr(3, 8'h20);
    chk("R12", "abort pulse", eng_abort, 1);
    rd(2, v); chk("R12", "busy bits after kill", v & 8'h03, 0);
    stall = 0;
    wdat[0] = 8'h5a; wdat[1] = 8'ha5;
    run_simple(3'd3, 7'h31, 1'b0, 8'h44);

    // R13 timeout
    wr(2, 8'h40); stall = 1; clear_log();
    wr(4, 8'h60); wr(0, 8'h1e); wr(3, 8'h10);
    repeat (TMO + 20) @(negedge clk);
    rd(0, v); chk("R13", "error after timeout", v & 8'h0a, 8'h02);
    rd(2, v); chk("R13", "control after timeout", v, 8'h40);
    stall = 0; wr(2, 8'h00); wr(0, 8'h1e);

    // R8 block writes
    run_bwrite(7'h10, 8'h01, 0);
    run_bwrite(7'h10, 8'h02, 5);
    run_bwrite(7'h11, 8'h03, 8);
    run_bwrite(7'h12, 8'h04, 9);
    run_bwrite(7'h13, 8'h05, 32);
    run_bwrite(7'h14, 8'h06, 45);
    for (int it = 0; it < 4; it++) run_bwrite(7'($urandom), 8'($urandom), $urandom_range(40, 1));

    // R9 block reads
    run_bread(7'h20, 8'h11, 8'd0);
    run_bread(7'h21, 8'h12, 8'd3);
    run_bread(7'h22, 8'h13, 8'd8);
    run_bread(7'h23, 8'h14, 8'd9);
    run_bread(7'h24, 8'h15, 8'd32);
    run_bread(7'h25, 8'h16, 8'd200);
    for (int it = 0; it < 4; it++) run_bread(7'($urandom), 8'($urandom), 8'($urandom_range(40, 1)));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule